// File: doc/BRIEF.md
# String Word Sequencer

This block copies a run of bytes between memory and a block of consecutive general-purpose registers. It is given a first register index, a byte count from 0 to 128, a start address and a direction. It then works through the run on its own. Whole 32-bit words are moved first. A final stretch of one to three bytes is then moved one byte at a time. Bytes are packed big-endian, so the first byte of a word or of the tail sits in register bits 31:24.

The block has four interfaces. The first is a start interface that takes one pulse. The second is a memory request port that can move either a full word or a single byte, and each access waits for a ready handshake. The third is a register-file port with a combinational read path and a write strobe. The last is a one-cycle completion pulse. Register indices run upward and wrap from 31 back to 0, so a long run can cover the whole register file. Alignment faults and overlap between the registers being filled and any base register are not handled here.

Top module: `strmove_seq`

## Requirements
- R1: A start with a byte count of 0 raises `done_o` in the cycle after the start is taken. It makes no memory request and no register write.
- R2: While four or more bytes remain, each handshake moves one 32-bit word (`mem_byte_o` = 0). On a load the full word goes unchanged into the register. On a store the full register goes unchanged onto `mem_wdata_o`. After each word the address grows by 4 and the register index by 1.
- R3: The register index wraps from 31 to 0 when the run passes the last register.
- R4: The last 1 to 3 bytes use byte accesses (`mem_byte_o` = 1) at consecutive addresses, each one greater than the last, and all of them use the same register. The count of word accesses is the byte count divided by 4, and the count of byte accesses is the remainder.
- R5: On a load, the tail bytes fill the register in this order: bits 31:24, then 23:16, then 15:8. Byte reads return the data on `mem_rdata_i[7:0]`. Any low bytes that are not filled are written as zero.
- R6: On a store, the tail bytes are taken from the register in the order 31:24, 23:16, 15:8. Each byte is presented on `mem_wdata_o[7:0]` with bits 31:8 at zero.
- R7: An access that is not yet accepted (`mem_rdy_i` low) holds its request, address, size and direction until it is accepted.
- R8: `done_o` is a single-cycle pulse. It comes in the cycle after the final handshake, and `busy_o` is low while it is high. A start that arrives while `busy_o` is high is ignored.
- R9: On a load, each register is written (`rf_we_o`) in the same cycle as the handshake that completes it.
- R10: During and after reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are low.
- R11: The direction input uses 1 for store and 0 for load. A store never writes the register file, and a load never raises `mem_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| store_i | input | 1 | Direction: 1 store, 0 load |
| start_reg_i | input | RW (5) | First register index |
| byte_cnt_i | input | CW (8) | Number of bytes, 0 to 128 |
| start_addr_i | input | AW (32) | First byte address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_byte_o | output | 1 | 1 byte access, 0 word access |
| mem_addr_o | output | AW (32) | Access address |
| mem_wdata_o | output | DW (32) | Write data (byte in bits 7:0 for byte access) |
| mem_rdata_i | input | DW (32) | Read data (byte in bits 7:0 for byte access) |
| mem_rdy_i | input | 1 | Access accepted this cycle |
| rf_raddr_o | output | RW (5) | Register read index |
| rf_rdata_i | input | DW (32) | Register read data (combinational) |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | RW (5) | Register write index |
| rf_wdata_o | output | DW (32) | Register write data |

## Verification
The bench compares the full register file and memory image after every run against a reference model. If a design filled the tail from the wrong end, or left stale low bytes in the last register, the final register would come out wrong. Runs of 128 bytes from register 31, and short runs that start at register 30, catch a design that does not wrap the index; such a design would write out of range or stop early. The bench also counts word and byte handshakes to catch a design that splits the run in the wrong place. It stalls the memory at random to catch a design that moves its address before the handshake. Zero-length starts and starts sent while busy expose a design that touches memory with nothing to move, or that lets a second run corrupt the first.

// File: rtl/strmove_pkg.sv
`timescale 1ns/1ps
package strmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORD = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strmove_fsm.sv
`timescale 1ns/1ps
// Phase controller: idle, whole-word phase, byte tail phase, plus completion pulse.
module strmove_fsm
  import strmove_pkg::*;
#(
  parameter int CW  = 8,
  parameter int BPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] rem_i,
  input  logic          mem_rdy_i,
  output seq_state_e    state_o,
  output logic          accept_o,
  output logic          fire_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [CW-1:0] WSTEP = CW'(BPW);
  localparam logic [CW-1:0] ONE   = CW'(1);

  seq_state_e    state_q, state_d;
  logic          done_q, done_d;
  logic [CW-1:0] rem_after;

  always_comb begin
    accept_o  = (state_q == ST_IDLE) && start_i;
    fire_o    = (state_q != ST_IDLE) && mem_rdy_i;
    last_o    = ((state_q == ST_WORD) && (rem_i == WSTEP)) ||
                ((state_q == ST_TAIL) && (rem_i == ONE));
    rem_after = rem_i - WSTEP;
    state_d   = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o && (cnt_i != '0)) begin
          state_d = (cnt_i < WSTEP) ? ST_TAIL : ST_WORD;
        end
      end
      ST_WORD: begin
        if (fire_o) begin
          if (last_o) begin
            state_d = ST_IDLE;
          end else if (rem_after < WSTEP) begin
            state_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (fire_o && last_o) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = (accept_o && (cnt_i == '0)) || (fire_o && last_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/strmove_lane.sv
`timescale 1ns/1ps
// Byte-lane selection: picks the tail byte out of a register and inserts a
// fetched tail byte into the packing accumulator, most significant lane first.
module strmove_lane #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [LW-1:0] lane_i,
  input  logic [DW-1:0] word_i,
  input  logic [7:0]    byte_i,
  input  logic [DW-1:0] acc_i,
  output logic [7:0]    byte_o,
  output logic [DW-1:0] acc_o
);
  localparam int NL = DW / 8;

  logic [NL-1:0][7:0]    pick;
  logic [NL-1:0][DW-1:0] ins;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign pick[k] = (lane_i == LW'(k)) ? word_i[DW-1-8*k -: 8] : 8'h00;
    assign ins[k]  = (lane_i == LW'(k)) ? ({byte_i, {(DW-8){1'b0}}} >> (8*k))
                                        : {DW{1'b0}};
  end

  always_comb begin
    byte_o = 8'h00;
    acc_o  = acc_i;
    for (int k = 0; k < NL; k++) begin
      byte_o = byte_o | pick[k];
      acc_o  = acc_o | ins[k];
    end
  end
endmodule

// File: rtl/strmove_dp.sv
`timescale 1ns/1ps
// Run state: address, register index, bytes left, tail lane, packing accumulator.
module strmove_dp
  import strmove_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RW  = 5,
  parameter int CW  = 8,
  parameter int BPW = 4,
  parameter int LW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          fire_i,
  input  seq_state_e    state_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [RW-1:0] start_reg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dir_i,
  input  logic [DW-1:0] acc_next_i,
  output logic [AW-1:0] addr_o,
  output logic [RW-1:0] ridx_o,
  output logic [CW-1:0] rem_o,
  output logic [LW-1:0] lane_o,
  output logic [DW-1:0] acc_o,
  output logic          dir_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [RW-1:0] ridx_q, ridx_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [LW-1:0] lane_q, lane_d;
  logic [DW-1:0] acc_q, acc_d;
  logic          dir_q, dir_d;
  logic          en;

  always_comb begin
    en     = accept_i | fire_i;
    addr_d = addr_q;
    ridx_d = ridx_q;
    rem_d  = rem_q;
    lane_d = lane_q;
    acc_d  = acc_q;
    dir_d  = dir_q;
    if (accept_i) begin
      addr_d = start_addr_i;
      ridx_d = start_reg_i;
      rem_d  = cnt_i;
      lane_d = '0;
      acc_d  = '0;
      dir_d  = dir_i;
    end else if (fire_i && (state_i == ST_WORD)) begin
      addr_d = addr_q + AW'(BPW);
      ridx_d = ridx_q + RW'(1);
      rem_d  = rem_q - CW'(BPW);
    end else if (fire_i && (state_i == ST_TAIL)) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - CW'(1);
      lane_d = lane_q + LW'(1);
      acc_d  = acc_next_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ridx_q <= '0;
      rem_q  <= '0;
      lane_q <= '0;
      acc_q  <= '0;
      dir_q  <= 1'b0;
    end else if (en) begin
      addr_q <= addr_d;
      ridx_q <= ridx_d;
      rem_q  <= rem_d;
      lane_q <= lane_d;
      acc_q  <= acc_d;
      dir_q  <= dir_d;
    end
  end

  assign addr_o = addr_q;
  assign ridx_o = ridx_q;
  assign rem_o  = rem_q;
  assign lane_o = lane_q;
  assign acc_o  = acc_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/strmove_seq.sv
`timescale 1ns/1ps
// Top: moves a byte run between memory and consecutive registers.
module strmove_seq
  import strmove_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int RW        = 5,
  parameter int MAX_BYTES = 128,
  localparam int BPW      = DW / 8,
  localparam int CW       = $clog2(MAX_BYTES + 1),
  localparam int LW       = $clog2(BPW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          store_i,
  input  logic [RW-1:0] start_reg_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_byte_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  seq_state_e    state;
  logic          accept, fire, last;
  logic [AW-1:0] addr;
  logic [RW-1:0] ridx;
  logic [CW-1:0] rem;
  logic [LW-1:0] lane;
  logic [DW-1:0] acc, acc_next;
  logic          dir;
  logic [7:0]    tail_byte;
  logic          in_word, in_tail;

  strmove_fsm #(.CW(CW), .BPW(BPW)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cnt_i     (byte_cnt_i),
    .rem_i     (rem),
    .mem_rdy_i (mem_rdy_i),
    .state_o   (state),
    .accept_o  (accept),
    .fire_o    (fire),
    .last_o    (last),
    .done_o    (done_o)
  );

  strmove_dp #(.AW(AW), .DW(DW), .RW(RW), .CW(CW), .BPW(BPW), .LW(LW)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .fire_i       (fire),
    .state_i      (state),
    .start_addr_i (start_addr_i),
    .start_reg_i  (start_reg_i),
    .cnt_i        (byte_cnt_i),
    .dir_i        (store_i),
    .acc_next_i   (acc_next),
    .addr_o       (addr),
    .ridx_o       (ridx),
    .rem_o        (rem),
    .lane_o       (lane),
    .acc_o        (acc),
    .dir_o        (dir)
  );

  strmove_lane #(.DW(DW), .LW(LW)) lane_i (
    .lane_i (lane),
    .word_i (rf_rdata_i),
    .byte_i (mem_rdata_i[7:0]),
    .acc_i  (acc),
    .byte_o (tail_byte),
    .acc_o  (acc_next)
  );

  always_comb begin
    in_word     = (state == ST_WORD);
    in_tail     = (state == ST_TAIL);
    busy_o      = (state != ST_IDLE);
    mem_req_o   = busy_o;
    mem_we_o    = busy_o && dir;
    mem_byte_o  = in_tail;
    mem_addr_o  = addr;
    mem_wdata_o = in_word ? rf_rdata_i : {{(DW-8){1'b0}}, tail_byte};
    rf_raddr_o  = ridx;
    rf_waddr_o  = ridx;
    rf_we_o     = fire && !dir && (in_word || (in_tail && last));
    rf_wdata_o  = in_word ? mem_rdata_i : acc_next;
  end
endmodule

// File: rtl/strmove_seq_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks, bound into the top module.
module strmove_seq_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RW  = 5,
  parameter int CW  = 8,
  parameter int BPW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] byte_cnt_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_byte_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          mem_rdy_i,
  input logic [RW-1:0] rf_raddr_o,
  input logic          rf_we_o,
  input logic [DW-1:0] rf_wdata_o
);
  a_r1_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (byte_cnt_i == '0)) |=> (done_o && !mem_req_o));

  a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i && !mem_byte_o) |=>
      (!mem_req_o || ((mem_addr_o == $past(mem_addr_o) + AW'(BPW)) &&
                      (rf_raddr_o == $past(rf_raddr_o) + RW'(1)))));

  a_r4_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i && mem_byte_o) |=>
      (!mem_req_o || (mem_byte_o && (mem_addr_o == $past(mem_addr_o) + AW'(1)) &&
                      $stable(rf_raddr_o))));

  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_byte_o) |-> (mem_wdata_o[DW-1:8] == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_byte_o) && $stable(mem_we_o)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_write_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_rdy_i && !mem_we_o));

  a_r9_word_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !mem_byte_o) |-> (rf_wdata_o == mem_rdata_i));
endmodule

bind strmove_seq strmove_seq_chk #(
  .AW(AW), .DW(DW), .RW(RW), .CW(CW), .BPW(BPW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .byte_cnt_i  (byte_cnt_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_byte_o  (mem_byte_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_rdy_i   (mem_rdy_i),
  .rf_raddr_o  (rf_raddr_o),
  .rf_we_o     (rf_we_o),
  .rf_wdata_o  (rf_wdata_o)
);

// File: tb/strmove_seq_tb_top.sv
`timescale 1ns/1ps
module strmove_seq_tb_top;
  localparam int MSZ = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, store;
  logic [4:0]  sreg;
  logic [7:0]  cnt;
  logic [31:0] saddr;
  logic        busy, done;
  logic        mem_req, mem_we, mem_byte, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;

  logic [7:0]  mem     [MSZ];
  logic [7:0]  exp_mem [MSZ];
  logic [31:0] rf      [32];
  logic [31:0] exp_rf  [32];
  logic [9:0]  ma;

  int n_checks = 0;
  int n_err    = 0;
  int n_word, n_byte, bad_dir, hold_err, lane_err;
  logic        store_op = 1'b0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr;
  logic        pend_byte;

  always #4 clk = ~clk;

  strmove_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .store_i(store),
    .start_reg_i(sreg), .byte_cnt_i(cnt), .start_addr_i(saddr),
    .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_byte_o(mem_byte),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rdy_i(mem_rdy),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  // Memory and register-file models; big-endian byte order for words.
  always_comb begin
    ma = mem_addr[9:0];
    if (mem_byte) mem_rdata = {24'h0, mem[ma]};
    else mem_rdata = {mem[ma], mem[ma+10'd1], mem[ma+10'd2], mem[ma+10'd3]};
    rf_rdata = rf[rf_raddr];
  end

  always @(negedge clk) mem_rdy = (($urandom % 4) != 0);

  always @(posedge clk) begin
    if (pend) begin
      if (!mem_req || mem_addr !== pend_addr || mem_byte !== pend_byte) hold_err++;
    end
    pend      = mem_req && !mem_rdy;
    pend_addr = mem_addr;
    pend_byte = mem_byte;
    if (mem_req && mem_rdy) begin
      if (mem_byte) n_byte++; else n_word++;
      if (mem_we) begin
        if (mem_byte) begin
          mem[ma] = mem_wdata[7:0];
          if (mem_wdata[31:8] != 24'h0) lane_err++;
        end else begin
          mem[ma] = mem_wdata[31:24]; mem[ma+10'd1] = mem_wdata[23:16];
          mem[ma+10'd2] = mem_wdata[15:8]; mem[ma+10'd3] = mem_wdata[7:0];
        end
      end
    end
    if (mem_req && mem_we && !store_op) bad_dir++;
    if (rf_we) begin
      if (store_op) bad_dir++;
      rf[rf_waddr] = rf_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic ref_apply(input logic st, input logic [4:0] r, input logic [7:0] n,
                           input logic [31:0] a);
    int rr = r;
    int aa = a[9:0];
    int left = n;
    logic [31:0] acc;
    while (left >= 4) begin
      if (st) begin
        exp_mem[aa] = exp_rf[rr][31:24]; exp_mem[aa+1] = exp_rf[rr][23:16];
        exp_mem[aa+2] = exp_rf[rr][15:8]; exp_mem[aa+3] = exp_rf[rr][7:0];
      end else begin
        exp_rf[rr] = {exp_mem[aa], exp_mem[aa+1], exp_mem[aa+2], exp_mem[aa+3]};
      end
      rr = (rr + 1) % 32;
      aa += 4;
      left -= 4;
    end
    if (left > 0) begin
      acc = 32'h0;
      for (int k = 0; k < left; k++) begin
        if (st) exp_mem[aa+k] = 8'(exp_rf[rr] >> (24 - 8*k));
        else acc = acc | ({exp_mem[aa+k], 24'h0} >> (8*k));
      end
      if (!st) exp_rf[rr] = acc;
    end
  endtask

  task automatic run_op(input logic st, input logic [4:0] r, input logic [7:0] n,
                        input logic [31:0] a, input logic poke);
    int cyc;
    int bad;
    for (int i = 0; i < 32; i++) begin
      rf[i] = $urandom;
      exp_rf[i] = rf[i];
    end
    for (int i = 0; i < MSZ; i++) exp_mem[i] = mem[i];
    ref_apply(st, r, n, a);
    @(negedge clk);
    store = st; sreg = r; cnt = n; saddr = a; start = 1'b1; store_op = st;
    n_word = 0; n_byte = 0; bad_dir = 0; hold_err = 0; lane_err = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      start = poke && busy && (cyc == 1);
      if (start) begin
        store = ~st; sreg = r + 5'd3; cnt = 8'd9; saddr = a + 32'd48;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, "R8 done reached", {31'h0, done}, 32'h1);
    if (n == 0) begin
      check(cyc == 0, "R1 zero-count done latency", cyc, 0);
      check(n_word + n_byte == 0, "R1 zero-count accesses", n_word + n_byte, 0);
    end else begin
      check(n_word == n / 4, "R2 word access count", n_word, n / 4);
      check(n_byte == n % 4, "R4 byte access count", n_byte, n % 4);
    end
    @(negedge clk);
    check(!done && !busy, "R8 done single pulse", {30'h0, done, busy}, 32'h0);
    bad = -1;
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i] && bad < 0) bad = i;
    check(bad < 0, st ? "R11 store leaves registers" : "R2 R3 R5 R9 load registers",
          (bad < 0) ? 32'h0 : rf[bad], (bad < 0) ? 32'h0 : exp_rf[bad]);
    bad = -1;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_mem[i] && bad < 0) bad = i;
    check(bad < 0, st ? "R2 R3 R6 store memory" : "R11 load leaves memory",
          (bad < 0) ? 32'h0 : {24'h0, mem[bad]}, (bad < 0) ? 32'h0 : {24'h0, exp_mem[bad]});
    check(hold_err == 0, "R7 stalled access held", hold_err, 0);
    check(bad_dir == 0, "R11 direction respected", bad_dir, 0);
    check(lane_err == 0, "R6 byte write upper bits zero", lane_err, 0);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL R8 watchdog: got no completion expected done");
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 1'b0; start = 1'b0; store = 1'b0; sreg = '0; cnt = '0; saddr = '0;
    mem_rdy = 1'b0;
    for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    repeat (3) @(negedge clk);
    check({busy, done, mem_req, rf_we} == 4'b0, "R10 outputs in reset",
          {28'h0, busy, done, mem_req, rf_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, mem_req, rf_we} == 4'b0, "R10 outputs after reset",
          {28'h0, busy, done, mem_req, rf_we}, 32'h0);

    // Directed corner cases.
    run_op(1'b0, 5'd5, 8'd0, 32'd100, 1'b0);   // R1 load, nothing to move
    run_op(1'b1, 5'd9, 8'd0, 32'd200, 1'b0);   // R1 store, nothing to move
    run_op(1'b0, 5'd3, 8'd1, 32'd17, 1'b0);    // R5 single tail byte
    run_op(1'b0, 5'd4, 8'd2, 32'd33, 1'b0);    // R5 two tail bytes
    run_op(1'b0, 5'd6, 8'd3, 32'd50, 1'b0);    // R5 three tail bytes
    run_op(1'b1, 5'd3, 8'd1, 32'd300, 1'b0);   // R6 single tail byte
    run_op(1'b1, 5'd8, 8'd3, 32'd311, 1'b0);   // R6 three tail bytes
    run_op(1'b0, 5'd10, 8'd4, 32'd400, 1'b0);  // R2 exactly one word
    run_op(1'b1, 5'd11, 8'd7, 32'd410, 1'b0);  // R2 R4 word then tail
    run_op(1'b0, 5'd30, 8'd9, 32'd500, 1'b0);  // R3 wrap inside run
    run_op(1'b0, 5'd31, 8'd128, 32'd600, 1'b0); // R3 full file from 31
    run_op(1'b1, 5'd17, 8'd128, 32'd64, 1'b0); // R3 full store with wrap
    run_op(1'b0, 5'd2, 8'd20, 32'd700, 1'b1);  // R8 start ignored while busy
    run_op(1'b1, 5'd29, 8'd13, 32'd720, 1'b1); // R8 start ignored while busy

    // Seeded random runs.
    for (int t = 0; t < 40; t++) begin
      run_op(1'($urandom), 5'($urandom), 8'($urandom % 129),
             32'($urandom % 860), (($urandom % 4) == 0));
    end
    finish_run();
  end
endmodule